// File: doc/BRIEF.md
# Majority-Vote Asynchronous Serial Receiver

This block recovers characters from a single asynchronous serial input line. An external rate generator supplies a one-clock oversampling tick. The receiver waits for the idle-high line to fall, then times each bit with a tick counter. It takes three samples around the middle of every bit and decides the bit by majority. A counter of sixteen ticks per bit is used at normal speed; a double-speed mode halves this to eight.

Frame shape is set by a three-bit size code, a two-bit parity mode and the speed select. Characters of 5 to 9 data bits arrive least-significant bit first, optionally followed by an even or odd parity bit, then by the stop bit. A received character goes into a holding register with its frame and parity status. It stays there until software acknowledges it. A character that completes while the holding register is still unread is dropped, and an overrun flag is raised.

Top module: `serial_rx_vote`

## Requirements
- R1: The line idles high; a low level seen on a tick while idle starts a frame. If the start bit votes high at its centre, the frame is abandoned and no character is produced.
- R2: With `dbl_speed`=0, each bit lasts 16 ticks and is decided from oversample positions 8, 9 and 10. A disturbance confined to positions 2 to 6 of a bit has no effect.
- R3: With `dbl_speed`=1, each bit lasts 8 ticks and is decided from positions 4, 5 and 6.
- R4: A bit is 0 when at least two of its three samples are low and 1 when at least two are high, so a single-tick glitch inside the window cannot change it.
- R5: `size_code` 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits; codes 4 to 6 select 8. The first received data bit lands in `rx_data[0]`, and unused upper bits read 0.
- R6: `size_code`=7 selects 9 data bits; the ninth received bit appears on `rx_bit8`, which reads 0 for shorter characters.
- R7: `parity_mode[1]`=1 enables a parity bit after the data; `parity_mode[0]`=0 means even and 1 means odd, taken over all data bits. A mismatch sets `parity_err` for that character.
- R8: While `parity_mode[1]`=0, `parity_err` reads 0, even if the held character was received with a parity mismatch.
- R9: A first stop bit that votes low sets `frame_err` for that character.
- R10: The character completes when the first stop bit is decided. The receiver then looks for the next start. `rx_valid` rises, and `rx_strobe` pulses for exactly one clock. `rd_ack` clears `rx_valid` and `overrun`.
- R11: A character that completes while `rx_valid` is 1 and not being acknowledged sets `overrun`. The held data and flags stay unchanged, and no strobe occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-clock oversampling tick |
| rxd | input | 1 | Serial input line, idle high |
| dbl_speed | input | 1 | 1 = 8 ticks per bit, 0 = 16 |
| size_code | input | 3 | Character size select |
| parity_mode | input | 2 | [1] parity enable, [0] odd parity |
| rd_ack | input | 1 | Acknowledge of the held character |
| rx_data | output | 8 | Held data bits 0 to 7 |
| rx_bit8 | output | 1 | Held ninth data bit |
| rx_valid | output | 1 | Held character unread |
| rx_strobe | output | 1 | One-clock pulse when a character is stored |
| frame_err | output | 1 | Held character had a low stop bit |
| parity_err | output | 1 | Held character failed parity (gated by enable) |
| overrun | output | 1 | A character was lost while unread |

## Verification
The bench uses the default parameters: 16 ticks per bit at normal speed and a two-stage input synchronizer. It drives one tick every four clocks, so the synchronizer delay stays below one tick. This places the voting window within known line positions, which lets glitch windows be aimed at the voting samples or kept clear of them. With eight ticks per bit in double-speed mode, the same window scheme shows the vote moving to the earlier positions.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  localparam int MAX_BITS = 9;
  localparam int IDX_W    = $clog2(MAX_BITS + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP
  } rx_state_t;

  // two-of-three decision
  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // data bit count for a size code
  function automatic logic [IDX_W-1:0] data_bits(input logic [2:0] code);
    case (code)
      3'd0: return IDX_W'(5);
      3'd1: return IDX_W'(6);
      3'd2: return IDX_W'(7);
      3'd7: return IDX_W'(9);
      default: return IDX_W'(8);
    endcase
  endfunction

  // 1 when the received parity bit disagrees with the selected sense
  function automatic logic parity_bad(input logic [MAX_BITS-1:0] d,
                                      input logic pbit, input logic odd);
    return ((^d) ^ pbit) != odd;
  endfunction

endpackage

// File: rtl/rx_sampler.sv
module rx_sampler
  import serial_rx_pkg::*;
#(
  parameter int OS_RATE     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic rxd,
  input  logic dbl,
  input  logic frame_end,
  output logic start_pulse,
  output logic bit_strobe,
  output logic bit_value
);
  localparam int CW = $clog2(OS_RATE + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rx_s;
  logic                   running;
  logic                   dbl_l;
  logic [CW-1:0]          cnt;
  logic [CW-1:0]          cnt_nxt;
  logic [CW-1:0]          os_cur;
  logic [CW-1:0]          lo_pos;
  logic                   s_lo, s_mid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], rxd};
  end
  assign rx_s = sync_q[SYNC_STAGES-1];

  always_comb begin
    os_cur  = dbl_l ? CW'(OS_RATE / 2) : CW'(OS_RATE);
    lo_pos  = os_cur >> 1;
    cnt_nxt = (cnt == os_cur) ? CW'(1) : cnt + CW'(1);
  end

  assign start_pulse = tick & ~running & ~rx_s;
  assign bit_strobe  = tick & running & (cnt_nxt == lo_pos + CW'(2));
  assign bit_value   = vote3(s_lo, s_mid, rx_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      dbl_l   <= 1'b0;
      cnt     <= '0;
      s_lo    <= 1'b1;
      s_mid   <= 1'b1;
    end else if (tick) begin
      if (!running) begin
        if (!rx_s) begin
          running <= 1'b1;
          cnt     <= CW'(1);
          dbl_l   <= dbl;
        end
      end else if (frame_end) begin
        running <= 1'b0;
      end else begin
        cnt <= cnt_nxt;
        if (cnt_nxt == lo_pos)          s_lo  <= rx_s;
        if (cnt_nxt == lo_pos + CW'(1)) s_mid <= rx_s;
      end
    end
  end

  // a frame may only begin after the synchronized line was seen low
  assert_start_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> !$past(rx_s));

  // after the first stop bit (or a false start) the sampler hunts again
  assert_return_hunt_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && tick) |=> !running);

endmodule

// File: rtl/rx_frame.sv
module rx_frame
  import serial_rx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_pulse,
  input  logic                bit_strobe,
  input  logic                bit_value,
  input  logic [2:0]          size_code,
  input  logic [1:0]          parity_mode,
  output logic                frame_end,
  output logic                char_done,
  output logic [MAX_BITS-1:0] char_data,
  output logic                char_ferr,
  output logic                char_perr
);
  rx_state_t           state;
  logic [IDX_W-1:0]    idx;
  logic [IDX_W-1:0]    nbits_l;
  logic                par_en_l, par_odd_l;
  logic [MAX_BITS-1:0] shreg;
  logic                pbit;

  assign frame_end = bit_strobe &
                     (((state == ST_START) & bit_value) | (state == ST_STOP));
  assign char_done = bit_strobe & (state == ST_STOP);
  assign char_data = shreg;
  assign char_ferr = ~bit_value;
  assign char_perr = par_en_l & parity_bad(shreg, pbit, par_odd_l);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      idx       <= '0;
      nbits_l   <= IDX_W'(8);
      par_en_l  <= 1'b0;
      par_odd_l <= 1'b0;
      shreg     <= '0;
      pbit      <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start_pulse) begin
          state     <= ST_START;
          nbits_l   <= data_bits(size_code);
          par_en_l  <= parity_mode[1];
          par_odd_l <= parity_mode[0];
        end
        ST_START: if (bit_strobe) begin
          if (bit_value) state <= ST_IDLE;
          else begin
            state <= ST_DATA;
            idx   <= '0;
            shreg <= '0;
            pbit  <= 1'b0;
          end
        end
        ST_DATA: if (bit_strobe) begin
          shreg[idx] <= bit_value;
          idx        <= idx + IDX_W'(1);
          if (idx == nbits_l - IDX_W'(1))
            state <= par_en_l ? ST_PAR : ST_STOP;
        end
        ST_PAR: if (bit_strobe) begin
          pbit  <= bit_value;
          state <= ST_STOP;
        end
        ST_STOP: if (bit_strobe) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // a start bit that votes high abandons the frame
  assert_false_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_strobe && state == ST_START && bit_value) |=> state == ST_IDLE);

endmodule

// File: rtl/rx_hold.sv
module rx_hold
  import serial_rx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                char_done,
  input  logic [MAX_BITS-1:0] char_data,
  input  logic                char_ferr,
  input  logic                char_perr,
  input  logic                rd_ack,
  input  logic                par_en_live,
  output logic [7:0]          rx_data,
  output logic                rx_bit8,
  output logic                rx_valid,
  output logic                rx_strobe,
  output logic                frame_err,
  output logic                parity_err,
  output logic                overrun
);
  logic perr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data   <= '0;
      rx_bit8   <= 1'b0;
      rx_valid  <= 1'b0;
      rx_strobe <= 1'b0;
      frame_err <= 1'b0;
      perr_q    <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      rx_strobe <= 1'b0;
      if (rd_ack) begin
        rx_valid <= 1'b0;
        overrun  <= 1'b0;
      end
      if (char_done) begin
        if (rx_valid && !rd_ack) begin
          overrun <= 1'b1;
        end else begin
          rx_data   <= char_data[7:0];
          rx_bit8   <= char_data[MAX_BITS-1];
          frame_err <= char_ferr;
          perr_q    <= char_perr;
          rx_valid  <= 1'b1;
          rx_strobe <= 1'b1;
        end
      end
    end
  end

  assign parity_err = perr_q & par_en_live;

  assert_overrun_keep_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (char_done && rx_valid && !rd_ack) |=>
      (overrun && $stable(rx_data) && $stable(rx_bit8) && !rx_strobe));

  assert_store_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (char_done && !(rx_valid && !rd_ack)) |=> (rx_valid && rx_strobe));

  assert_ack_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ack && !char_done) |=> (!rx_valid && !overrun));

endmodule

// File: rtl/serial_rx_vote.sv
module serial_rx_vote
  import serial_rx_pkg::*;
#(
  parameter int OS_RATE     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic       rxd,
  input  logic       dbl_speed,
  input  logic [2:0] size_code,
  input  logic [1:0] parity_mode,
  input  logic       rd_ack,
  output logic [7:0] rx_data,
  output logic       rx_bit8,
  output logic       rx_valid,
  output logic       rx_strobe,
  output logic       frame_err,
  output logic       parity_err,
  output logic       overrun
);
  logic                start_pulse, bit_strobe, bit_value, frame_end;
  logic                char_done, char_ferr, char_perr;
  logic [MAX_BITS-1:0] char_data;

  rx_sampler #(.OS_RATE(OS_RATE), .SYNC_STAGES(SYNC_STAGES)) u_samp (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .rxd(rxd), .dbl(dbl_speed),
    .frame_end(frame_end), .start_pulse(start_pulse),
    .bit_strobe(bit_strobe), .bit_value(bit_value)
  );

  rx_frame u_frame (
    .clk(clk), .rst_n(rst_n), .start_pulse(start_pulse),
    .bit_strobe(bit_strobe), .bit_value(bit_value),
    .size_code(size_code), .parity_mode(parity_mode),
    .frame_end(frame_end), .char_done(char_done), .char_data(char_data),
    .char_ferr(char_ferr), .char_perr(char_perr)
  );

  rx_hold u_hold (
    .clk(clk), .rst_n(rst_n), .char_done(char_done), .char_data(char_data),
    .char_ferr(char_ferr), .char_perr(char_perr), .rd_ack(rd_ack),
    .par_en_live(parity_mode[1]), .rx_data(rx_data), .rx_bit8(rx_bit8),
    .rx_valid(rx_valid), .rx_strobe(rx_strobe), .frame_err(frame_err),
    .parity_err(parity_err), .overrun(overrun)
  );

endmodule

// File: tb/sim_serial_rx_vote.sv
`timescale 1ns/1ps
module sim_serial_rx_vote;
  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       baud_tick;
  logic       rxd = 1'b1;
  logic       dbl_speed = 1'b0;
  logic [2:0] size_code = 3'd3;
  logic [1:0] parity_mode = 2'b00;
  logic       rd_ack = 1'b0;
  logic [7:0] rx_data;
  logic       rx_bit8, rx_valid, rx_strobe, frame_err, parity_err, overrun;

  int checks = 0;
  int fails  = 0;
  int strobes = 0;
  int tick_cnt = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  always @(posedge clk) tick_cnt <= (tick_cnt == DIV - 1) ? 0 : tick_cnt + 1;
  assign baud_tick = (tick_cnt == 0);
  always @(posedge clk) if (rx_strobe) strobes <= strobes + 1;

  serial_rx_vote u0 (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rxd(rxd),
    .dbl_speed(dbl_speed), .size_code(size_code), .parity_mode(parity_mode),
    .rd_ack(rd_ack), .rx_data(rx_data), .rx_bit8(rx_bit8), .rx_valid(rx_valid),
    .rx_strobe(rx_strobe), .frame_err(frame_err), .parity_err(parity_err),
    .overrun(overrun)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one bit: gs/gl mark a window of ticks driven to the opposite level
  task automatic send_bit(input bit v, input int os, input int gs, input int gl);
    for (int t = 0; t < os; t++) begin
      rxd = (t >= gs && t < gs + gl) ? ~v : v;
      repeat (DIV) @(negedge clk);
    end
  endtask

  task automatic send_frame(input logic [8:0] val, input int nb, input bit pen,
                            input bit podd, input bit pflip, input bit stopv,
                            input int gbit, input int gs, input int gl);
    int os;
    bit pb;
    os = dbl_speed ? 8 : 16;
    pb = 1'b0;
    for (int i = 0; i < nb; i++) pb ^= val[i];
    pb = pb ^ podd ^ pflip;
    @(negedge clk);
    send_bit(1'b0, os, 0, 0);
    for (int i = 0; i < nb; i++)
      send_bit(val[i], os, (i == gbit) ? gs : 0, (i == gbit) ? gl : 0);
    if (pen) send_bit(pb, os, 0, 0);
    send_bit(stopv, os, 0, 0);
    send_bit(1'b1, 2 * os, 0, 0);
  endtask

  task automatic ack();
    @(negedge clk); rd_ack = 1'b1;
    @(negedge clk); rd_ack = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R10 reset valid", rx_valid, 0);
    chk("R10 reset data", rx_data, 0);
    chk("R9 reset ferr", frame_err, 0);
    chk("R11 reset ovr", overrun, 0);
  endtask

  task automatic t_byte();
    int s0 = strobes;
    size_code = 3'd3; parity_mode = 2'b00; dbl_speed = 1'b0;
    send_frame(9'h0A5, 8, 0, 0, 0, 1, -1, 0, 0);
    chk("R2 data 8-bit", rx_data, 8'hA5);
    chk("R10 valid", rx_valid, 1);
    chk("R10 one strobe", strobes - s0, 1);
    chk("R9 good stop", frame_err, 0);
    ack();
    chk("R10 ack clears", rx_valid, 0);
  endtask

  task automatic t_sizes();
    size_code = 3'd0;
    send_frame(9'h1FB, 5, 0, 0, 0, 1, -1, 0, 0);
    chk("R5 5-bit", rx_data, 8'h1B);
    ack();
    size_code = 3'd2;
    send_frame(9'h1D5, 7, 0, 0, 0, 1, -1, 0, 0);
    chk("R5 7-bit", rx_data, 8'h55);
    chk("R6 bit8 low short", rx_bit8, 0);
    ack();
    size_code = 3'd5;
    send_frame(9'h03C, 8, 0, 0, 0, 1, -1, 0, 0);
    chk("R5 code5 as 8-bit", rx_data, 8'h3C);
    ack();
    size_code = 3'd7;
    send_frame(9'h1C3, 9, 0, 0, 0, 1, -1, 0, 0);
    chk("R6 9-bit low byte", rx_data, 8'hC3);
    chk("R6 ninth bit", rx_bit8, 1);
    ack();
    size_code = 3'd3;
  endtask

  task automatic t_parity();
    parity_mode = 2'b10;
    send_frame(9'h0B7, 8, 1, 0, 0, 1, -1, 0, 0);
    chk("R7 even ok", parity_err, 0);
    chk("R7 even data", rx_data, 8'hB7);
    ack();
    parity_mode = 2'b11;
    send_frame(9'h0B7, 8, 1, 1, 1, 1, -1, 0, 0);
    chk("R7 odd mismatch", parity_err, 1);
    parity_mode = 2'b00;
    @(negedge clk);
    chk("R8 gated when disabled", parity_err, 0);
    parity_mode = 2'b11;
    @(negedge clk);
    chk("R7 flag held", parity_err, 1);
    ack();
    parity_mode = 2'b11;
    size_code = 3'd7;
    send_frame(9'h100, 9, 1, 1, 0, 1, -1, 0, 0);
    chk("R7 odd over 9 bits", parity_err, 0);
    chk("R7 ninth bit", rx_bit8, 1);
    ack();
    size_code = 3'd3; parity_mode = 2'b00;
  endtask

  task automatic t_frame_err();
    int s0 = strobes;
    send_frame(9'h05A, 8, 0, 0, 0, 0, -1, 0, 0);
    chk("R9 low stop", frame_err, 1);
    chk("R9 data", rx_data, 8'h5A);
    chk("R1 no spurious char", strobes - s0, 1);
    ack();
  endtask

  task automatic t_false_start();
    int s0 = strobes;
    @(negedge clk);
    send_bit(1'b0, 4, 0, 0);
    send_bit(1'b1, 40, 0, 0);
    chk("R1 false start no strobe", strobes - s0, 0);
    chk("R1 false start no valid", rx_valid, 0);
    send_frame(9'h081, 8, 0, 0, 0, 1, -1, 0, 0);
    chk("R1 recovers", rx_data, 8'h81);
    ack();
  endtask

  task automatic t_overrun();
    int s0 = strobes;
    send_frame(9'h011, 8, 0, 0, 0, 1, -1, 0, 0);
    send_frame(9'h022, 8, 0, 0, 0, 0, -1, 0, 0);
    chk("R11 overrun set", overrun, 1);
    chk("R11 old data kept", rx_data, 8'h11);
    chk("R11 old ferr kept", frame_err, 0);
    chk("R11 single strobe", strobes - s0, 1);
    ack();
    chk("R10 ack clears overrun", overrun, 0);
  endtask

  task automatic t_vote();
    dbl_speed = 1'b0;
    send_frame(9'h000, 8, 0, 0, 0, 1, 3, 8, 1);
    chk("R4 one-tick glitch ignored", rx_data, 8'h00);
    ack();
    send_frame(9'h000, 8, 0, 0, 0, 1, 3, 5, 7);
    chk("R4 majority flips bit", rx_data, 8'h08);
    ack();
    send_frame(9'h000, 8, 0, 0, 0, 1, 3, 1, 5);
    chk("R2 early window ignored", rx_data, 8'h00);
    ack();
    dbl_speed = 1'b1;
    send_frame(9'h03C, 8, 0, 0, 0, 1, -1, 0, 0);
    chk("R3 double speed data", rx_data, 8'h3C);
    ack();
    send_frame(9'h000, 8, 0, 0, 0, 1, 5, 2, 6);
    chk("R3 double window flips", rx_data, 8'h20);
    ack();
    send_frame(9'h0FF, 8, 0, 0, 0, 1, 2, 4, 1);
    chk("R4 double one-tick glitch", rx_data, 8'hFF);
    ack();
    dbl_speed = 1'b0;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    t_byte();
    t_sizes();
    t_parity();
    t_frame_err();
    t_false_start();
    t_overrun();
    t_vote();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule